// File: doc/BRIEF.md
# Timer Compare Match Unit

This block pairs a 16-bit up-counting timer with a compare register and acts whenever the two are equal. It compares only on cycles where the timer clock enable is high. On such a cycle, if the count equals the compare value, the 4-bit action code decides what happens:

- the output latch is toggled, set or cleared;
- or only the interrupt flag is raised;
- or a trigger strobe fires, which restarts the timer and can request an ADC conversion.

Used as a period source, the trigger code makes the timer count 0..N and restart, giving a programmable period of N+1 ticks.

Software reaches the block through one write port. A 2-bit select picks the target of each write: the compare value, the action code or a preload of the timer count. The interrupt flag stays set until a clear strobe arrives. The latch's output-enable tells the pad logic whether the current action code drives the pin.

Top module: `tcm_unit`

## Requirements
- R1: After synchronous active-low reset, the following are all zero: timer count, output latch, output-enable, interrupt flag, trigger strobe, convert request and wrap pulse.
- R2: The timer count rises by one on each cycle with `tick` high and holds otherwise. A write with `wr_sel`=2'b10 loads the count from `wr_data`, and this load takes priority over a tick in the same cycle.
- R3: A compare match is plain 16-bit equality of count and compare value, evaluated only on cycles with `tick` high. While `tick` is low, an equal count causes no action.
- R4: Action code 4'b0010 (written with `wr_sel`=2'b01, code in `wr_data[3:0]`) inverts the output latch on each match and holds `cmp_oe` high.
- R5: Action code 4'b1000 drives the latch high on a match and 4'b1001 drives it low; both hold `cmp_oe` high.
- R6: A match under codes 0010, 1000, 1001, 1010 or 1011 sets `irq_flag`. The flag holds until `irq_clr` is pulsed, and a match in the same cycle as `irq_clr` leaves it set.
- R7: Code 4'b1010 sets the flag only: `cmp_oe` is low, the latch keeps its value and no trigger is issued.
- R8: Code 4'b1011 raises `trig` combinationally in the match cycle, while the count still shows the matched value, with `cmp_oe` low. At the edge that closes that cycle, the count goes to zero instead of incrementing, and `tmr_wrap` is not pulsed even when the matched value is 16'hFFFF.
- R9: A compare value rewritten before the timer tick so that equality no longer holds cancels the pending trigger and timer restart: the count increments normally.
- R10: `adc_start` follows `trig` when `adc_en` is high and stays low when `adc_en` is low.
- R11: Writing action code 4'b0000 forces the output latch low on the next cycle.
- R12: Code 0000 and every code not listed in R4 to R8 take no action on a match: no flag, no latch change, no trigger, `cmp_oe` low.
- R13: A tick with the count at 16'hFFFF (outside a trigger restart) wraps the count to zero and raises `tmr_wrap` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable; one timer step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 compare value, 01 action code, 10 timer count, 11 none |
| wr_data | input | 16 | Write data; action code in bits 3:0 |
| adc_en | input | 1 | Allows the trigger to request a conversion |
| irq_clr | input | 1 | Clears the interrupt flag |
| cmp_out | output | 1 | Compare output latch |
| cmp_oe | output | 1 | High when the action code drives the pin |
| irq_flag | output | 1 | Sticky match interrupt flag |
| trig | output | 1 | Trigger strobe in the match cycle of code 1011 |
| adc_start | output | 1 | Conversion request |
| tmr_count | output | 16 | Current timer count |
| tmr_wrap | output | 1 | One-cycle pulse on natural timer overflow |

## Verification
The checker assumes that `rst_n` is held low for at least one rising edge before any property counts. It also assumes that a timer preload and a trigger restart can meet in the same cycle, so the restart property excuses cycles carrying a preload write. The stimulus changes every input just after a falling edge and holds it for a whole cycle. It performs all register writes with `tick` low, except where a test deliberately combines a write and a tick, and it pulses `irq_clr` for single cycles only.

// File: rtl/tcm_pkg.sv
// Package: shared constants and types for the timer compare match unit.
// Assumes a 4-bit action code and a 2-bit write select.
package tcm_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] ACT_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] ACT_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] ACT_SET    = 4'b1000;
    localparam logic [MODE_W-1:0] ACT_CLEAR  = 4'b1001;
    localparam logic [MODE_W-1:0] ACT_IRQ    = 4'b1010;
    localparam logic [MODE_W-1:0] ACT_TRIG   = 4'b1011;

    typedef enum logic [1:0] {
        SEL_CMP  = 2'b00,
        SEL_MODE = 2'b01,
        SEL_TMR  = 2'b10,
        SEL_NONE = 2'b11
    } wr_sel_e;

    // One-cycle match event decoded from the action code
    typedef struct packed {
        logic hit;
        logic toggle;
        logic set;
        logic clear;
        logic trig;
    } cmp_evt_t;

endpackage

// File: rtl/tcm_timer.sv
// Module: free-running up-counter with preload and trigger restart.
// Assumes load has priority over tick and over the trigger restart.
// The wrap pulse marks natural overflow only, never a trigger restart.
module tcm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: advance, preload or restart the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= restart ? '0 : count + 1'b1;
        end
    end

    // Purpose: flag a natural rollover from all-ones to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap <= 1'b0;
        end else begin
            wrap <= !load && tick && !restart && (count == CNT_MAX);
        end
    end

endmodule

// File: rtl/tcm_match.sv
// Module: equality comparator and action decode (combinational).
// Assumes the action code is already registered; only the listed codes act.
module tcm_match
    import tcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [MODE_W-1:0] mode,
    output cmp_evt_t          evt,
    output logic              pin_drive
);

    logic equal;
    logic known;

    // Purpose: detect equality and whether the code is a compare action
    always_comb begin
        equal = (count == cmp_val);
        known = (mode == ACT_TOGGLE) || (mode == ACT_SET) || (mode == ACT_CLEAR)
             || (mode == ACT_IRQ)    || (mode == ACT_TRIG);
    end

    // Purpose: build the per-action event strobes for a ticked match
    always_comb begin
        evt.hit    = tick && equal && known;
        evt.toggle = evt.hit && (mode == ACT_TOGGLE);
        evt.set    = evt.hit && (mode == ACT_SET);
        evt.clear  = evt.hit && (mode == ACT_CLEAR);
        evt.trig   = evt.hit && (mode == ACT_TRIG);
    end

    // Purpose: only latch-affecting codes take the pin
    always_comb begin
        pin_drive = (mode == ACT_TOGGLE) || (mode == ACT_SET) || (mode == ACT_CLEAR);
    end

endmodule

// File: rtl/tcm_out.sv
// Module: output latch and sticky interrupt flag.
// Assumes a write of the off code overrides any match action in that cycle,
// and a match overrides a flag clear in the same cycle.
module tcm_out
    import tcm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmp_evt_t evt,
    input  logic     force_low,
    input  logic     irq_clr,
    output logic     latch,
    output logic     irq
);

    // Purpose: update the compare output latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= 1'b0;
        end else if (force_low) begin
            latch <= 1'b0;
        end else if (evt.toggle) begin
            latch <= !latch;
        end else if (evt.set) begin
            latch <= 1'b1;
        end else if (evt.clear) begin
            latch <= 1'b0;
        end
    end

    // Purpose: hold the interrupt flag until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (evt.hit) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/tcm_unit.sv
// Module: timer compare match unit top.
// Holds the compare and action registers and joins timer, comparator and
// output stage. Assumes CNT_W is at least MODE_W so the code fits wr_data.
module tcm_unit
    import tcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             adc_en,
    input  logic             irq_clr,
    output logic             cmp_out,
    output logic             cmp_oe,
    output logic             irq_flag,
    output logic             trig,
    output logic             adc_start,
    output logic [CNT_W-1:0] tmr_count,
    output logic             tmr_wrap
);

    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              wr_cmp;
    logic              wr_mode;
    logic              wr_tmr;
    logic              mode_off_wr;
    cmp_evt_t          evt;

    // Purpose: decode the write select
    always_comb begin
        wr_cmp      = wr_en && (wr_sel == SEL_CMP);
        wr_mode     = wr_en && (wr_sel == SEL_MODE);
        wr_tmr      = wr_en && (wr_sel == SEL_TMR);
        mode_off_wr = wr_mode && (wr_data[MODE_W-1:0] == ACT_OFF);
    end

    // Purpose: hold the compare value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= wr_data;
        end
    end

    // Purpose: hold the action code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ACT_OFF;
        end else if (wr_mode) begin
            mode_q <= wr_data[MODE_W-1:0];
        end
    end

    tcm_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_tmr),
        .load_val (wr_data),
        .restart  (evt.trig),
        .count    (tmr_count),
        .wrap     (tmr_wrap)
    );

    tcm_match #(.CNT_W(CNT_W)) i_match (
        .tick      (tick),
        .count     (tmr_count),
        .cmp_val   (cmp_q),
        .mode      (mode_q),
        .evt       (evt),
        .pin_drive (cmp_oe)
    );

    tcm_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .force_low (mode_off_wr),
        .irq_clr   (irq_clr),
        .latch     (cmp_out),
        .irq       (irq_flag)
    );

    // Purpose: export the trigger and gate the conversion request
    always_comb begin
        trig      = evt.trig;
        adc_start = evt.trig && adc_en;
    end

endmodule

// File: rtl/tcm_unit_chk.sv
// Module: property checker for tcm_unit, bound to every instance.
// Assumes reset is applied before any property is relevant.
module tcm_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             adc_en,
    input logic             irq_clr,
    input logic             cmp_out,
    input logic             cmp_oe,
    input logic             irq_flag,
    input logic             trig,
    input logic             adc_start,
    input logic [CNT_W-1:0] tmr_count,
    input logic             tmr_wrap,
    input logic [CNT_W-1:0] cmp_q,
    input logic [3:0]       mode_q
);

    logic act_code;
    logic off_wr;
    logic tmr_wr;

    always_comb begin
        act_code = (mode_q == 4'b0010) || (mode_q == 4'b1000) || (mode_q == 4'b1001)
                || (mode_q == 4'b1010) || (mode_q == 4'b1011);
        off_wr   = wr_en && (wr_sel == 2'b01) && (wr_data[3:0] == 4'b0000);
        tmr_wr   = wr_en && (wr_sel == 2'b10);
    end

    a_r3_no_trig_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !trig);

    a_r6_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tmr_count == cmp_q) && act_code) |=> irq_flag);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    a_r7_irq_only_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tmr_count == cmp_q) && (mode_q == 4'b1010) && !off_wr) |=> $stable(cmp_out));

    a_r8_trig_releases_pin: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> !cmp_oe);

    a_r8_trig_restarts_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !tmr_wr) |=> ((tmr_count == '0) && !tmr_wrap));

    a_r10_adc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (trig && adc_en));

    a_r11_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |=> !cmp_out);

endmodule

bind tcm_unit tcm_unit_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .adc_en    (adc_en),
    .irq_clr   (irq_clr),
    .cmp_out   (cmp_out),
    .cmp_oe    (cmp_oe),
    .irq_flag  (irq_flag),
    .trig      (trig),
    .adc_start (adc_start),
    .tmr_count (tmr_count),
    .tmr_wrap  (tmr_wrap),
    .cmp_q     (cmp_q),
    .mode_q    (mode_q)
);

// File: tb/test_tcm_unit.sv
module test_tcm_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        adc_en;
    logic        irq_clr;
    logic        cmp_out;
    logic        cmp_oe;
    logic        irq_flag;
    logic        trig;
    logic        adc_start;
    logic [15:0] tmr_count;
    logic        tmr_wrap;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tcm_unit i_tcm_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .adc_en    (adc_en),
        .irq_clr   (irq_clr),
        .cmp_out   (cmp_out),
        .cmp_oe    (cmp_oe),
        .irq_flag  (irq_flag),
        .trig      (trig),
        .adc_start (adc_start),
        .tmr_count (tmr_count),
        .tmr_wrap  (tmr_wrap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: let the edge pass, return at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        cyc();
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cmp_out", cmp_out, 0);
        check("R1 cmp_oe", cmp_oe, 0);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 trig", trig, 0);
        check("R1 adc_start", adc_start, 0);
        check("R1 count", tmr_count, 0);
        check("R1 wrap", tmr_wrap, 0);
    endtask

    task automatic t_count();
        ticks(3);
        check("R2 count after 3 ticks", tmr_count, 3);
        cyc(); cyc();
        check("R2 count holds without tick", tmr_count, 3);
        wr(2'b10, 16'h1234);
        check("R2 preload", tmr_count, 16'h1234);
        tick = 1'b1;
        wr(2'b10, 16'h0100);
        tick = 1'b0;
        check("R2 load beats tick", tmr_count, 16'h0100);
    endtask

    task automatic t_toggle();
        wr(2'b00, 16'h0020);
        wr(2'b01, 16'h0002);
        wr(2'b10, 16'h0020);
        cyc(); cyc(); cyc();
        check("R3 no action without tick (latch)", cmp_out, 0);
        check("R3 no action without tick (flag)", irq_flag, 0);
        check("R4 oe in toggle", cmp_oe, 1);
        ticks(1);
        check("R4 first toggle", cmp_out, 1);
        check("R6 flag set by toggle match", irq_flag, 1);
        check("R3 one tick one step", tmr_count, 16'h0021);
        ticks(1);
        check("R3 no match at 0x21", cmp_out, 1);
        wr(2'b10, 16'h0020);
        tick = 1'b1; irq_clr = 1'b1;
        cyc();
        tick = 1'b0; irq_clr = 1'b0;
        check("R4 second toggle", cmp_out, 0);
        check("R6 set wins over clear", irq_flag, 1);
        pulse_clr();
        check("R6 clear drops flag", irq_flag, 0);
    endtask

    task automatic t_setclr();
        wr(2'b01, 16'h0008);
        check("R5 oe in set", cmp_oe, 1);
        wr(2'b10, 16'h0020);
        ticks(1);
        check("R5 set on match", cmp_out, 1);
        ticks(1);
        check("R5 set holds off match", cmp_out, 1);
        wr(2'b01, 16'h0009);
        check("R5 oe in clear", cmp_oe, 1);
        wr(2'b10, 16'h0020);
        ticks(1);
        check("R5 clear on match", cmp_out, 0);
        pulse_clr();
    endtask

    task automatic t_irq_only();
        wr(2'b01, 16'h0008);
        wr(2'b10, 16'h0020);
        ticks(1);
        pulse_clr();
        wr(2'b01, 16'h000A);
        check("R7 oe low", cmp_oe, 0);
        wr(2'b10, 16'h0020);
        tick = 1'b1;
        #1;
        check("R7 no trigger", trig, 0);
        cyc();
        tick = 1'b0;
        check("R7 flag set", irq_flag, 1);
        check("R7 latch kept", cmp_out, 1);
        pulse_clr();
    endtask

    task automatic t_off_and_unknown();
        wr(2'b01, 16'h0000);
        check("R11 off write clears latch", cmp_out, 0);
        wr(2'b10, 16'h0020);
        ticks(1);
        check("R12 off: no flag", irq_flag, 0);
        check("R12 off: oe low", cmp_oe, 0);
        wr(2'b01, 16'h0008);
        wr(2'b10, 16'h0020);
        ticks(1);
        pulse_clr();
        wr(2'b01, 16'h0005);
        wr(2'b10, 16'h0020);
        tick = 1'b1;
        #1;
        check("R12 unknown: no trig", trig, 0);
        cyc();
        tick = 1'b0;
        check("R12 unknown: no flag", irq_flag, 0);
        check("R12 unknown: latch kept", cmp_out, 1);
        check("R12 unknown: oe low", cmp_oe, 0);
        wr(2'b01, 16'h0000);
        check("R11 off write from high", cmp_out, 0);
    endtask

    task automatic t_trig();
        wr(2'b00, 16'h0040);
        wr(2'b01, 16'h000B);
        check("R8 oe low", cmp_oe, 0);
        adc_en = 1'b0;
        wr(2'b10, 16'h0040);
        tick = 1'b1;
        #1;
        check("R8 trig in match cycle", trig, 1);
        check("R8 count not yet cleared", tmr_count, 16'h0040);
        check("R10 no request when disabled", adc_start, 0);
        cyc();
        tick = 1'b0;
        check("R8 count restarted", tmr_count, 0);
        check("R8 no wrap", tmr_wrap, 0);
        check("R6 flag in trigger mode", irq_flag, 1);
        check("R8 trig gone", trig, 0);
        pulse_clr();
        adc_en = 1'b1;
        wr(2'b10, 16'h0040);
        tick = 1'b1;
        #1;
        check("R10 request when enabled", adc_start, 1);
        cyc();
        tick = 1'b0;
        check("R10 request ends", adc_start, 0);
        adc_en = 1'b0;
        pulse_clr();
    endtask

    task automatic t_cancel();
        wr(2'b00, 16'h0050);
        wr(2'b10, 16'h0050);
        wr(2'b00, 16'h0060);
        tick = 1'b1;
        #1;
        check("R9 no trig after rewrite", trig, 0);
        cyc();
        tick = 1'b0;
        check("R9 count increments", tmr_count, 16'h0051);
        check("R9 no flag", irq_flag, 0);
    endtask

    task automatic t_wrap();
        wr(2'b01, 16'h0000);
        wr(2'b10, 16'hFFFF);
        ticks(1);
        check("R13 wraps to zero", tmr_count, 0);
        check("R13 wrap pulse", tmr_wrap, 1);
        cyc();
        check("R13 pulse one cycle", tmr_wrap, 0);
        wr(2'b00, 16'hFFFF);
        wr(2'b01, 16'h000B);
        wr(2'b10, 16'hFFFF);
        ticks(1);
        check("R8 restart at all-ones", tmr_count, 0);
        check("R8 no wrap on restart", tmr_wrap, 0);
        pulse_clr();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = 2'b11;
        wr_data = '0; adc_en = 1'b0; irq_clr = 1'b0;
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_count();
        t_toggle();
        t_setclr();
        t_irq_only();
        t_off_and_unknown();
        t_trig();
        t_cancel();
        t_wrap();
        finish_run();
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule